// File: doc/BRIEF.md
# Page and ordering-ID hazard tracker

This block holds a small table of translation requests that are in flight. It makes sure that two requests run one after the other when they would do the same work or when they must stay in order. A request is accepted on the register port and placed in a slot. From then on the block reports, for each slot, whether that request may proceed or must wait. A slot waits while an older entry that is still live blocks it. That happens in two cases: the older entry sits on the same 4 KB page, whatever either direction is, or it carries the same ordering ID in the same direction (read or write). When the request is done, its owner releases the slot through the release port. A slot held back is granted again as soon as its last blocking elder has gone.

Age means arrival order, not slot number. A slot that is freed and reused holds the youngest request in the table, even when its index is low. A request whose byte range runs past the end of its 4 KB page is refused and flagged on an error output. A release that names an empty slot is also flagged, and it changes nothing. A release is applied before a registration in the same cycle, so a full table can take a new request in the same cycle that a slot is freed.

Top module: `hazard_order_tracker`

## Requirements
- R1: The page tag of a request is `reg_addr` with its low 12 bits dropped. A live request is held (`page_hold` high, `grant` low) while an older live entry has the same page tag.
- R2: A request whose page offset (`reg_addr[11:0]`) plus `reg_size` is greater than 4096 is not registered. `err_cross` is then high for one cycle in the cycle after it was offered. An offset plus size of exactly 4096 is accepted.
- R3: The page check ignores direction: an older write on the same page holds a younger read, and an older read holds a younger write.
- R4: A live request is held (`id_hold` high) while an older live entry has the same `reg_id` and the same `reg_write` value. An older entry with the same ID and the other direction does not hold it.
- R5: Only older entries block a request. A request reusing a lower-numbered slot is younger than every entry already present and never blocks them.
- R6: An accepted request takes the lowest-numbered free slot. `reg_slot` shows that index while the request is offered, and the matching `slot_busy` bit is high from the next cycle on.
- R7: When no slot is free, `reg_ready` is low and an offered request leaves the table unchanged.
- R8: A release of a busy slot frees it in the next cycle. A release of a free slot leaves the table unchanged, and `err_release` is high for one cycle in the cycle after.
- R9: A release and a registration in the same cycle are applied release first. With a full table, the new request takes the slot being released.
- R10: A held request is granted in the cycle after its last blocking older entry is released.
- R11: After reset all slots are free, no grant or hold is high, both error outputs are low and `reg_ready` is high.
- R12: Whenever any slot is busy, at least one slot is granted, namely the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | A request is offered for registration |
| reg_ready | output | 1 | A slot is free after this cycle's release |
| reg_addr | input | ADDR_W | Start byte address of the request |
| reg_size | input | SIZE_W | Request length in bytes |
| reg_id | input | ID_W | Ordering ID |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_slot | output | SLOT_W | Slot the offered request would occupy |
| rel_valid | input | 1 | A release is requested |
| rel_slot | input | SLOT_W | Slot to release |
| slot_busy | output | SLOTS | Slot holds a live request |
| page_hold | output | SLOTS | Slot is held by an older same-page entry |
| id_hold | output | SLOTS | Slot is held by an older same-ID, same-direction entry |
| grant | output | SLOTS | Slot is live and free to proceed |
| err_cross | output | 1 | Pulse: a page-crossing request was refused |
| err_release | output | 1 | Pulse: a release named a free slot |

## Verification
The checker assumes that the owner of a slot releases it only once and that `rel_slot` is always below the slot count. It also assumes that the inputs on the register port are stable for the whole cycle in which they are sampled. The stimulus drives every request for exactly one cycle, away from the clock edge. It releases free slots only on purpose, to provoke `err_release`. It never offers a page-crossing request in the same cycle as a release, so that the table-unchanged properties are not confused by a legal release.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PAGE_BYTES = 1 << PAGE_SHIFT;
endpackage

// File: rtl/hzd_alloc_pick.sv
module hzd_alloc_pick #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]  free_vec,
  output logic [SLOT_W-1:0] pick_idx,
  output logic              pick_any
);
  // Lowest index wins: scan from the top so the last hit is the smallest.
  always_comb begin
    pick_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (free_vec[i]) pick_idx = SLOT_W'(i);
    end
  end

  assign pick_any = |free_vec;
endmodule

// File: rtl/hzd_slot_store.sv
module hzd_slot_store #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [SLOT_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic              alloc_wr,
  input  logic              free_en,
  input  logic [SLOT_W-1:0] free_idx,
  output logic [SLOTS-1:0]  live,
  output logic [TAG_W-1:0]  tag   [SLOTS],
  output logic [ID_W-1:0]   oid   [SLOTS],
  output logic [SLOTS-1:0]  dir_wr
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic live_d, live_q;
    logic load_en;
    logic [TAG_W-1:0] tag_q;
    logic [ID_W-1:0]  oid_q;
    logic             wr_q;

    assign load_en = alloc_en && (alloc_idx == SLOT_W'(s));

    always_comb begin
      live_d = live_q;
      if (free_en && (free_idx == SLOT_W'(s))) live_d = 1'b0;
      if (load_en) live_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= live_d;
    end

    always_ff @(posedge clk) begin
      if (load_en) begin
        tag_q <= alloc_tag;
        oid_q <= alloc_id;
        wr_q  <= alloc_wr;
      end
    end

    assign live[s]   = live_q;
    assign tag[s]    = tag_q;
    assign oid[s]    = oid_q;
    assign dir_wr[s] = wr_q;
  end
endmodule

// File: rtl/hzd_age_matrix.sv
module hzd_age_matrix #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_idx,
  input  logic [SLOTS-1:0]  live_after,
  input  logic              drop_en,
  input  logic [SLOT_W-1:0] drop_idx,
  output logic [SLOTS-1:0]  elder [SLOTS]
);
  // elder[i][j] = 1: slot j was registered before slot i and is still live.
  for (genvar r = 0; r < SLOTS; r++) begin : g_row
    logic [SLOTS-1:0] row_d, row_q;
    logic             row_en;

    always_comb begin
      row_d = row_q;
      if (drop_en) row_d[drop_idx] = 1'b0;
      if (set_en && (set_idx == SLOT_W'(r))) begin
        row_d    = live_after;
        row_d[r] = 1'b0;
      end
    end

    assign row_en = set_en || drop_en;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_en) row_q <= row_d;
    end

    assign elder[r] = row_q;
  end
endmodule

// File: rtl/hzd_block_eval.sv
module hzd_block_eval #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned TAG_W = 20,
  parameter int unsigned ID_W  = 4
) (
  input  logic [SLOTS-1:0] live,
  input  logic [TAG_W-1:0] tag    [SLOTS],
  input  logic [ID_W-1:0]  oid    [SLOTS],
  input  logic [SLOTS-1:0] dir_wr,
  input  logic [SLOTS-1:0] elder  [SLOTS],
  output logic [SLOTS-1:0] page_blk,
  output logic [SLOTS-1:0] id_blk,
  output logic [SLOTS-1:0] go
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_me
    logic [SLOTS-1:0] pg_hit, id_hit;
    for (genvar j = 0; j < SLOTS; j++) begin : g_other
      logic ahead;
      assign ahead     = elder[i][j] && live[j];
      assign pg_hit[j] = ahead && (tag[j] == tag[i]);
      assign id_hit[j] = ahead && (oid[j] == oid[i]) && (dir_wr[j] == dir_wr[i]);
    end
    assign page_blk[i] = live[i] && (|pg_hit);
    assign id_blk[i]   = live[i] && (|id_hit);
    assign go[i]       = live[i] && !(|pg_hit) && !(|id_hit);
  end
endmodule

// File: rtl/hazard_order_tracker.sv
module hazard_order_tracker #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 13,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [SIZE_W-1:0] reg_size,
  input  logic [ID_W-1:0]   reg_id,
  input  logic              reg_write,
  output logic [SLOT_W-1:0] reg_slot,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic [SLOTS-1:0]  slot_busy,
  output logic [SLOTS-1:0]  page_hold,
  output logic [SLOTS-1:0]  id_hold,
  output logic [SLOTS-1:0]  grant,
  output logic              err_cross,
  output logic              err_release
);
  import hzd_pkg::*;

  localparam int unsigned TAG_W = ADDR_W - PAGE_SHIFT;
  localparam int unsigned SUM_W = ((SIZE_W > PAGE_SHIFT) ? SIZE_W : PAGE_SHIFT) + 1;

  logic [SLOTS-1:0] live;
  logic [TAG_W-1:0] tag   [SLOTS];
  logic [ID_W-1:0]  oid   [SLOTS];
  logic [SLOTS-1:0] dir_wr;
  logic [SLOTS-1:0] elder [SLOTS];

  logic [SUM_W-1:0] span_end;
  logic             crosses;
  logic             rel_ok;
  logic [SLOTS-1:0] rel_mask;
  logic [SLOTS-1:0] live_after;
  logic [SLOT_W-1:0] pick_idx;
  logic             pick_any;
  logic             accept;
  logic             err_cross_d, err_cross_q;
  logic             err_rel_d, err_rel_q;

  // Boundary check: offset within page plus length must stay within the page.
  assign span_end = SUM_W'(reg_addr[PAGE_SHIFT-1:0]) + SUM_W'(reg_size);
  assign crosses  = span_end > SUM_W'(PAGE_BYTES);

  // Release is applied first.
  assign rel_ok     = rel_valid && live[rel_slot];
  assign rel_mask   = rel_ok ? (SLOTS'(1) << rel_slot) : '0;
  assign live_after = live & ~rel_mask;

  hzd_alloc_pick #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .free_vec (~live_after),
    .pick_idx (pick_idx),
    .pick_any (pick_any)
  );

  assign accept = reg_valid && pick_any && !crosses;

  hzd_slot_store #(.SLOTS(SLOTS), .TAG_W(TAG_W), .ID_W(ID_W), .SLOT_W(SLOT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (accept),
    .alloc_idx (pick_idx),
    .alloc_tag (reg_addr[ADDR_W-1:PAGE_SHIFT]),
    .alloc_id  (reg_id),
    .alloc_wr  (reg_write),
    .free_en   (rel_ok),
    .free_idx  (rel_slot),
    .live      (live),
    .tag       (tag),
    .oid       (oid),
    .dir_wr    (dir_wr)
  );

  hzd_age_matrix #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (accept),
    .set_idx    (pick_idx),
    .live_after (live_after),
    .drop_en    (rel_ok),
    .drop_idx   (rel_slot),
    .elder      (elder)
  );

  hzd_block_eval #(.SLOTS(SLOTS), .TAG_W(TAG_W), .ID_W(ID_W)) u_eval (
    .live     (live),
    .tag      (tag),
    .oid      (oid),
    .dir_wr   (dir_wr),
    .elder    (elder),
    .page_blk (page_hold),
    .id_blk   (id_hold),
    .go       (grant)
  );

  always_comb begin
    err_cross_d = reg_valid && crosses;
    err_rel_d   = rel_valid && !live[rel_slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cross_q <= 1'b0;
      err_rel_q   <= 1'b0;
    end else begin
      err_cross_q <= err_cross_d;
      err_rel_q   <= err_rel_d;
    end
  end

  assign reg_ready   = pick_any;
  assign reg_slot    = pick_idx;
  assign slot_busy   = live;
  assign err_cross   = err_cross_q;
  assign err_release = err_rel_q;
endmodule

// File: rtl/hazard_order_tracker_chk.sv
module hazard_order_tracker_chk #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 13,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_ready,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [SIZE_W-1:0] reg_size,
  input logic [SLOT_W-1:0] reg_slot,
  input logic              rel_valid,
  input logic [SLOT_W-1:0] rel_slot,
  input logic [SLOTS-1:0]  slot_busy,
  input logic [SLOTS-1:0]  page_hold,
  input logic [SLOTS-1:0]  id_hold,
  input logic [SLOTS-1:0]  grant,
  input logic              err_cross,
  input logic              err_release
);
  logic over_page;
  assign over_page = (({1'b0, reg_addr[11:0]} + 14'(reg_size)) > 14'd4096);

  p_cross_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && over_page |=> err_cross);

  p_cross_noreg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && over_page && !rel_valid |=> $stable(slot_busy));

  p_alloc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_ready && !over_page |=> slot_busy[$past(reg_slot)]);

  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready && !rel_valid |=> $stable(slot_busy));

  p_bad_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && !slot_busy[rel_slot] |=> err_release);

  p_rel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid && slot_busy[rel_slot] &&
    !(reg_valid && reg_ready && !over_page && (reg_slot == rel_slot))
    |=> !slot_busy[$past(rel_slot)]);

  p_grant_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & (page_hold | id_hold | ~slot_busy)) == '0);

  p_oldest_go_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_busy) |-> (|grant));
endmodule

bind hazard_order_tracker hazard_order_tracker_chk #(
  .SLOTS(SLOTS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ID_W(ID_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_valid   (reg_valid),
  .reg_ready   (reg_ready),
  .reg_addr    (reg_addr),
  .reg_size    (reg_size),
  .reg_slot    (reg_slot),
  .rel_valid   (rel_valid),
  .rel_slot    (rel_slot),
  .slot_busy   (slot_busy),
  .page_hold   (page_hold),
  .id_hold     (id_hold),
  .grant       (grant),
  .err_cross   (err_cross),
  .err_release (err_release)
);

// File: tb/hazard_order_tracker_tb_top.sv
`timescale 1ns/1ps
module hazard_order_tracker_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_valid;
  logic        reg_ready;
  logic [31:0] reg_addr;
  logic [12:0] reg_size;
  logic [3:0]  reg_id;
  logic        reg_write;
  logic [3:0]  reg_slot;
  logic        rel_valid;
  logic [3:0]  rel_slot;
  logic [15:0] slot_busy, page_hold, id_hold, grant;
  logic        err_cross, err_release;

  int total = 0;
  int bad   = 0;
  logic [3:0] seen_slot;
  logic       seen_ready;

  hazard_order_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_id(reg_id), .reg_write(reg_write),
    .reg_slot(reg_slot), .rel_valid(rel_valid), .rel_slot(rel_slot),
    .slot_busy(slot_busy), .page_hold(page_hold), .id_hold(id_hold),
    .grant(grant), .err_cross(err_cross), .err_release(err_release)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        do_reg;
    logic [31:0] addr;
    logic [12:0] size;
    logic [3:0]  id;
    logic        wr;
    logic        do_rel;
    logic [3:0]  rel;
    logic [15:0] exp_busy;
    logic [15:0] exp_grant;
    logic        exp_ec;
    logic        exp_er;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R6: first request goes to slot 0, granted
    '{1'b1, 32'h0000_1010, 13'd8,    4'd1, 1'b0, 1'b0, 4'd0, 16'h0001, 16'h0001, 1'b0, 1'b0},
    // R1/R3: same page, other direction, held
    '{1'b1, 32'h0000_1800, 13'd4,    4'd2, 1'b1, 1'b0, 4'd0, 16'h0003, 16'h0001, 1'b0, 1'b0},
    // R4: same id, same direction (read), held
    '{1'b1, 32'h0000_2000, 13'd4,    4'd1, 1'b0, 1'b0, 4'd0, 16'h0007, 16'h0001, 1'b0, 1'b0},
    // R4: same id, other direction, not held
    '{1'b1, 32'h0000_3000, 13'd4,    4'd1, 1'b1, 1'b0, 4'd0, 16'h000F, 16'h0009, 1'b0, 1'b0},
    // R10: release slot 0 frees both waiters
    '{1'b0, 32'h0,         13'd0,    4'd0, 1'b0, 1'b1, 4'd0, 16'h000E, 16'h000E, 1'b0, 1'b0},
    // R2 boundary (exactly 4096) accepted; R5 reused slot 0 is youngest, held by slot 1
    '{1'b1, 32'h0000_1000, 13'd4096, 4'd5, 1'b0, 1'b0, 4'd0, 16'h000F, 16'h000E, 1'b0, 1'b0},
    // R2: crossing request refused
    '{1'b1, 32'h0000_4FFF, 13'd2,    4'd6, 1'b0, 1'b0, 4'd0, 16'h000F, 16'h000E, 1'b1, 1'b0},
    // R8: release of free slot 9 flagged, no change
    '{1'b0, 32'h0,         13'd0,    4'd0, 1'b0, 1'b1, 4'd9, 16'h000F, 16'h000E, 1'b0, 1'b1},
    // R10: releasing slot 1 lets slot 0 go
    '{1'b0, 32'h0,         13'd0,    4'd0, 1'b0, 1'b1, 4'd1, 16'h000D, 16'h000D, 1'b0, 1'b0},
    // R6: lowest free slot 1 reused, held by slot 0 (page and id)
    '{1'b1, 32'h0000_1004, 13'd4,    4'd5, 1'b0, 1'b0, 4'd0, 16'h000F, 16'h000D, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic dr, input logic [31:0] a, input logic [12:0] s,
                      input logic [3:0] id, input logic w, input logic dl, input logic [3:0] rs);
    @(negedge clk);
    reg_valid = dr; reg_addr = a; reg_size = s; reg_id = id; reg_write = w;
    rel_valid = dl; rel_slot = rs;
    #1;
    seen_slot  = reg_slot;
    seen_ready = reg_ready;
    @(posedge clk);
    #1;
    reg_valid = 1'b0;
    rel_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    reg_valid = 1'b0; rel_valid = 1'b0;
    reg_addr = '0; reg_size = '0; reg_id = '0; reg_write = 1'b0; rel_slot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R11: reset state
    check(slot_busy == 16'h0 && grant == 16'h0 && page_hold == 16'h0 && id_hold == 16'h0,
          "R11 tables", {slot_busy, grant}, 32'h0);
    check(reg_ready && !err_cross && !err_release, "R11 flags",
          {29'd0, reg_ready, err_cross, err_release}, 32'h4);

    for (int v = 0; v < NV; v++) begin
      step(VECS[v].do_reg, VECS[v].addr, VECS[v].size, VECS[v].id, VECS[v].wr,
           VECS[v].do_rel, VECS[v].rel);
      check(slot_busy == VECS[v].exp_busy, "R6/R8 busy", slot_busy, VECS[v].exp_busy);
      check(grant == VECS[v].exp_grant, "R1/R4/R5/R10 grant", grant, VECS[v].exp_grant);
      check(err_cross == VECS[v].exp_ec && err_release == VECS[v].exp_er, "R2/R8 errors",
            {err_cross, err_release}, {VECS[v].exp_ec, VECS[v].exp_er});
      check(slot_busy == 16'h0 || grant != 16'h0, "R12 oldest granted", grant, 32'h1);
    end
    // Last vector: slot 1 held by page and by id
    check(page_hold == 16'h0002 && id_hold == 16'h0002, "R1/R4 hold vectors",
          {page_hold, id_hold}, 32'h0002_0002);

    // Error pulses last one cycle (R2, R8)
    step(1'b0, 32'h0, 13'd0, 4'd0, 1'b0, 1'b0, 4'd0);
    check(!err_cross && !err_release, "R2 R8 pulse ends", {err_cross, err_release}, 32'h0);

    // Same id, same direction: id hold only, different pages (R4)
    do_reset();
    step(1'b1, 32'h0000_A000, 13'd16, 4'd7, 1'b1, 1'b0, 4'd0);
    step(1'b1, 32'h0000_B000, 13'd16, 4'd7, 1'b1, 1'b0, 4'd0);
    check(id_hold == 16'h0002 && page_hold == 16'h0 && grant == 16'h0001, "R4 id only",
          {id_hold, grant}, 32'h0002_0001);

    // Fill the table with distinct pages and ids (R6, R7)
    do_reset();
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 32'h0010_0000 + (k << 12), 13'd64, 4'(k), 1'b0, 1'b0, 4'd0);
      check(seen_slot == 4'(k), "R6 lowest slot", seen_slot, k);
    end
    check(slot_busy == 16'hFFFF && grant == 16'hFFFF, "R6 full table",
          {slot_busy, grant}, 32'hFFFF_FFFF);
    check(!reg_ready, "R7 ready low", reg_ready, 32'h0);
    step(1'b1, 32'h0010_0000, 13'd4, 4'd0, 1'b0, 1'b0, 4'd0);
    check(slot_busy == 16'hFFFF && grant == 16'hFFFF && page_hold == 16'h0, "R7 ignored",
          {slot_busy, grant}, 32'hFFFF_FFFF);

    // Release 5 and register on page of slot 3 in the same cycle (R9, R5, R1)
    step(1'b1, 32'h0010_3040, 13'd4, 4'd9, 1'b1, 1'b1, 4'd5);
    check(seen_ready && seen_slot == 4'd5, "R9 slot reused", seen_slot, 32'h5);
    check(slot_busy == 16'hFFFF && grant == 16'hFFDF, "R9 R5 younger held",
          {slot_busy, grant}, 32'hFFFF_FFDF);
    check(page_hold == 16'h0020, "R1 page hold", page_hold, 32'h0020);

    // Release slot 3: slot 5 granted next cycle (R10)
    step(1'b0, 32'h0, 13'd0, 4'd0, 1'b0, 1'b1, 4'd3);
    check(slot_busy == 16'hFFF7 && grant == 16'hFFF7, "R10 resume",
          {slot_busy, grant}, 32'hFFF7_FFF7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule